// File: doc/BRIEF.md
# Per-Colour Window Comparator Monitor

This block watches the sample streams of three colour channels. Each channel has its own acceptance window. Software sets the window as a signed shift of its centre away from a fixed nominal value, plus a total width. Every valid sample is compared with its channel's window. A sample above the window increments one counter and a sample below it increments a second counter. Both counters stop at their maximum value.

A start-of-image pulse does two things: it clears all counters and it loads the limits software has staged since the last image. A new configuration therefore never changes the window in the middle of an image. After an image, software reads the two counters of each channel. A lopsided pair points to drift in one direction. Roughly equal counts on both sides point to noise whose size is comparable to the window. Software can then trim the laser energy before the next image.

Top module: `colour_window_monitor`

## Requirements
- R1: After reset every counter reads 0, every staged configuration word reads 0, and every active-limits word reads lower = upper = NOMINAL (128).
- R2: With staged shift s (signed, OFS_W bits) and width w, the active limits are lower = max(0, NOMINAL + s - floor(w/2)) and upper = min(2^SAMPLE_W - 1, NOMINAL + s + floor(w/2)).
- R3: A valid sample strictly greater than upper increments the channel's above counter. A valid sample strictly less than lower increments its below counter. A sample equal to either limit changes neither counter.
- R4: Each channel compares only its own samples with its own limits and updates only its own counters.
- R5: A sample whose valid bit is low changes no counter.
- R6: A counter at 2^CNT_W - 1 stays there on further out-of-window samples.
- R7: A start-of-image pulse clears both counters of every channel. A valid sample in the same cycle as the pulse is counted against the newly loaded limits.
- R8: A configuration write is visible at once on the configuration read-back. The active limits keep their old values until the next start-of-image pulse.
- R9: Register address = channel index * 4 + field. The fields are: 0 configuration (shift in bits [OFS_W-1:0], width in bits [16+WID_W-1:16]), 1 above count, 2 below count, 3 active limits (lower in [SAMPLE_W-1:0], upper in [16+SAMPLE_W-1:16]). Read data appears in the cycle after the read strobe. An address with no channel reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sof | input | 1 | Start-of-image pulse |
| s_valid | input | NUM_CH | Per-channel sample valid |
| s_data | input | NUM_CH*SAMPLE_W | Per-channel samples, channel c at bits [c*SAMPLE_W +: SAMPLE_W] |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | CH_W+2 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, one cycle after reg_re |

## Verification
The bench drives samples exactly at each limit and one code beyond it. An off-by-one comparator would then count a sample sitting on a limit. It also sets shifts and widths that push one limit below zero and the other above full scale. Limit arithmetic without clamping would wrap around and report a nonsensical window. A sample is sent that lies inside the old window but outside the staged one, both before the pulse and in the same cycle as the pulse. A design that applies writes early, or that counts the pulse-cycle sample against stale limits, gives the wrong count. Finally, one counter is driven past full scale. A counter without saturation would wrap to a small value.

// File: rtl/cwm_pkg.sv
package cwm_pkg;
    localparam int REG_W = 32;

    typedef enum logic [1:0] {
        FLD_CFG    = 2'd0,
        FLD_ABOVE  = 2'd1,
        FLD_BELOW  = 2'd2,
        FLD_LIMITS = 2'd3
    } field_e;
endpackage

// File: rtl/cwm_limit_calc.sv
module cwm_limit_calc #(
    parameter int SAMPLE_W = 8,
    parameter int OFS_W    = 6,
    parameter int WID_W    = 8,
    parameter int NOMINAL  = 128
) (
    input  logic [OFS_W-1:0]    ofs,
    input  logic [WID_W-1:0]    wid,
    output logic [SAMPLE_W-1:0] lo,
    output logic [SAMPLE_W-1:0] hi
);
    localparam int SW = SAMPLE_W + 3;
    localparam logic signed [SW-1:0] MAX_S = SW'((1 << SAMPLE_W) - 1);
    localparam logic signed [SW-1:0] NOM_S = SW'(NOMINAL);

    logic signed [SW-1:0] centre_s;
    logic signed [SW-1:0] half_s;
    logic signed [SW-1:0] lo_s;
    logic signed [SW-1:0] hi_s;

    always_comb begin
        centre_s = NOM_S + $signed({{(SW-OFS_W){ofs[OFS_W-1]}}, ofs});
        half_s   = $signed({{(SW-WID_W+1){1'b0}}, wid[WID_W-1:1]});
        lo_s     = centre_s - half_s;
        hi_s     = centre_s + half_s;
        lo       = lo_s[SW-1] ? '0 : lo_s[SAMPLE_W-1:0];
        hi       = (hi_s > MAX_S) ? '1 : hi_s[SAMPLE_W-1:0];
    end

    // R2: the clamped window is never inverted
    always_comb begin
        a_r2_ordered: assert (lo <= hi || $isunknown({ofs, wid}));
    end
endmodule

// File: rtl/cwm_channel.sv
module cwm_channel #(
    parameter int SAMPLE_W = 8,
    parameter int CNT_W    = 16,
    parameter int NOMINAL  = 128
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                sof,
    input  logic                valid,
    input  logic [SAMPLE_W-1:0] data,
    input  logic [SAMPLE_W-1:0] new_lo,
    input  logic [SAMPLE_W-1:0] new_hi,
    output logic [SAMPLE_W-1:0] lo_q,
    output logic [SAMPLE_W-1:0] hi_q,
    output logic [CNT_W-1:0]    above_q,
    output logic [CNT_W-1:0]    below_q
);
    localparam logic [CNT_W-1:0]    CNT_MAX = '1;
    localparam logic [SAMPLE_W-1:0] NOM_V   = SAMPLE_W'(NOMINAL);

    typedef struct packed {
        logic [SAMPLE_W-1:0] lo;
        logic [SAMPLE_W-1:0] hi;
        logic [CNT_W-1:0]    above;
        logic [CNT_W-1:0]    below;
    } chan_t;

    chan_t st_d, st_q;
    logic [SAMPLE_W-1:0] eff_lo_d, eff_hi_d;

    always_comb begin
        st_d     = st_q;
        eff_lo_d = sof ? new_lo : st_q.lo;
        eff_hi_d = sof ? new_hi : st_q.hi;
        if (sof) begin
            st_d.lo    = new_lo;
            st_d.hi    = new_hi;
            st_d.above = '0;
            st_d.below = '0;
        end
        if (valid) begin
            if (data > eff_hi_d) begin
                if (st_d.above != CNT_MAX) st_d.above = st_d.above + 1'b1;
            end else if (data < eff_lo_d) begin
                if (st_d.below != CNT_MAX) st_d.below = st_d.below + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.lo    <= NOM_V;
            st_q.hi    <= NOM_V;
            st_q.above <= '0;
            st_q.below <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lo_q    = st_q.lo;
    assign hi_q    = st_q.hi;
    assign above_q = st_q.above;
    assign below_q = st_q.below;

    // R6: a full counter never wraps within an image
    a_r6_above_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (above_q == CNT_MAX && !sof) |=> above_q == CNT_MAX);
    a_r6_below_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (below_q == CNT_MAX && !sof) |=> below_q == CNT_MAX);
    // R7: a pulse with no sample leaves both counters at zero
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (sof && !valid) |=> (above_q == '0 && below_q == '0));
    // R8: limits move only on a start-of-image pulse
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !sof |=> ($stable(lo_q) && $stable(hi_q)));
    // R5: no sample, no count change
    a_r5_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!valid && !sof) |=> ($stable(above_q) && $stable(below_q)));
    // R3: at most one counter steps by one per sample
    a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!sof && above_q != CNT_MAX) |=>
        (above_q == $past(above_q) || (above_q == $past(above_q) + 1'b1 && $stable(below_q))));
endmodule

// File: rtl/cwm_regfile.sv
module cwm_regfile #(
    parameter int NUM_CH   = 3,
    parameter int CH_W     = 2,
    parameter int SAMPLE_W = 8,
    parameter int OFS_W    = 6,
    parameter int WID_W    = 8,
    parameter int CNT_W    = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         we,
    input  logic                         re,
    input  logic [CH_W+1:0]              addr,
    input  logic [cwm_pkg::REG_W-1:0]    wdata,
    input  logic [NUM_CH*CNT_W-1:0]      above,
    input  logic [NUM_CH*CNT_W-1:0]      below,
    input  logic [NUM_CH*SAMPLE_W-1:0]   lo,
    input  logic [NUM_CH*SAMPLE_W-1:0]   hi,
    output logic [NUM_CH*OFS_W-1:0]      ofs,
    output logic [NUM_CH*WID_W-1:0]      wid,
    output logic [cwm_pkg::REG_W-1:0]    rdata
);
    import cwm_pkg::*;

    typedef struct packed {
        logic [NUM_CH-1:0][OFS_W-1:0] ofs;
        logic [NUM_CH-1:0][WID_W-1:0] wid;
        logic [REG_W-1:0]             rdata;
    } regs_t;

    regs_t  rg_d, rg_q;
    field_e fld_d;
    logic [CH_W-1:0] idx_d;
    logic [REG_W-1:0] word_d;

    always_comb begin
        rg_d   = rg_q;
        fld_d  = field_e'(addr[1:0]);
        idx_d  = addr[CH_W+1:2];
        word_d = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (idx_d == CH_W'(c)) begin
                unique case (fld_d)
                    FLD_CFG: begin
                        word_d[OFS_W-1:0]     = rg_q.ofs[c];
                        word_d[16+WID_W-1:16] = rg_q.wid[c];
                    end
                    FLD_ABOVE: word_d[CNT_W-1:0] = above[c*CNT_W +: CNT_W];
                    FLD_BELOW: word_d[CNT_W-1:0] = below[c*CNT_W +: CNT_W];
                    FLD_LIMITS: begin
                        word_d[SAMPLE_W-1:0]     = lo[c*SAMPLE_W +: SAMPLE_W];
                        word_d[16+SAMPLE_W-1:16] = hi[c*SAMPLE_W +: SAMPLE_W];
                    end
                    default: word_d = '0;
                endcase
                if (we && fld_d == FLD_CFG) begin
                    rg_d.ofs[c] = wdata[OFS_W-1:0];
                    rg_d.wid[c] = wdata[16+WID_W-1:16];
                end
            end
        end
        if (re) rg_d.rdata = word_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rg_q <= '0;
        end else begin
            rg_q <= rg_d;
        end
    end

    assign ofs   = rg_q.ofs;
    assign wid   = rg_q.wid;
    assign rdata = rg_q.rdata;

    // R9: read data changes only after a read strobe
    a_r9_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !re |=> $stable(rdata));
endmodule

// File: rtl/colour_window_monitor.sv
module colour_window_monitor #(
    parameter int NUM_CH   = 3,
    parameter int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    parameter int SAMPLE_W = 8,
    parameter int OFS_W    = 6,
    parameter int WID_W    = 8,
    parameter int CNT_W    = 16,
    parameter int NOMINAL  = 128
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sof,
    input  logic [NUM_CH-1:0]          s_valid,
    input  logic [NUM_CH*SAMPLE_W-1:0] s_data,
    input  logic                       reg_we,
    input  logic                       reg_re,
    input  logic [CH_W+1:0]            reg_addr,
    input  logic [31:0]                reg_wdata,
    output logic [31:0]                reg_rdata
);
    logic [NUM_CH*OFS_W-1:0]    ofs_w;
    logic [NUM_CH*WID_W-1:0]    wid_w;
    logic [NUM_CH*SAMPLE_W-1:0] new_lo_w, new_hi_w, lo_w, hi_w;
    logic [NUM_CH*CNT_W-1:0]    above_w, below_w;

    cwm_regfile #(
        .NUM_CH(NUM_CH), .CH_W(CH_W), .SAMPLE_W(SAMPLE_W),
        .OFS_W(OFS_W), .WID_W(WID_W), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .re(reg_re),
        .addr(reg_addr), .wdata(reg_wdata),
        .above(above_w), .below(below_w), .lo(lo_w), .hi(hi_w),
        .ofs(ofs_w), .wid(wid_w), .rdata(reg_rdata)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        cwm_limit_calc #(
            .SAMPLE_W(SAMPLE_W), .OFS_W(OFS_W), .WID_W(WID_W), .NOMINAL(NOMINAL)
        ) u_calc (
            .ofs(ofs_w[c*OFS_W +: OFS_W]),
            .wid(wid_w[c*WID_W +: WID_W]),
            .lo(new_lo_w[c*SAMPLE_W +: SAMPLE_W]),
            .hi(new_hi_w[c*SAMPLE_W +: SAMPLE_W])
        );

        cwm_channel #(
            .SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W), .NOMINAL(NOMINAL)
        ) u_chan (
            .clk(clk), .rst_n(rst_n), .sof(sof),
            .valid(s_valid[c]),
            .data(s_data[c*SAMPLE_W +: SAMPLE_W]),
            .new_lo(new_lo_w[c*SAMPLE_W +: SAMPLE_W]),
            .new_hi(new_hi_w[c*SAMPLE_W +: SAMPLE_W]),
            .lo_q(lo_w[c*SAMPLE_W +: SAMPLE_W]),
            .hi_q(hi_w[c*SAMPLE_W +: SAMPLE_W]),
            .above_q(above_w[c*CNT_W +: CNT_W]),
            .below_q(below_w[c*CNT_W +: CNT_W])
        );
    end
endmodule

// File: tb/colour_window_monitor_bench.sv
`timescale 1ns/1ps
module colour_window_monitor_bench;
    localparam int NCH = 3;
    localparam int SW  = 8;
    localparam int CW  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sof = 1'b0;
    logic [NCH-1:0] s_valid = '0;
    logic [NCH*SW-1:0] s_data = '0;
    logic reg_we = 1'b0;
    logic reg_re = 1'b0;
    logic [3:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    colour_window_monitor #(.CNT_W(CW)) u_colour_window_monitor (
        .clk(clk), .rst_n(rst_n), .sof(sof), .s_valid(s_valid), .s_data(s_data),
        .reg_we(reg_we), .reg_re(reg_re), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int fld, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'(ch * 4 + fld); reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input int ch, input int fld, output logic [31:0] d);
        @(negedge clk);
        reg_re = 1'b1; reg_addr = 4'(ch * 4 + fld);
        @(negedge clk);
        reg_re = 1'b0;
        d = reg_rdata;
    endtask

    task automatic push(input logic [2:0] v, input int d0, input int d1, input int d2, input logic p);
        @(negedge clk);
        s_valid = v; sof = p;
        s_data = {8'(d2), 8'(d1), 8'(d0)};
        @(negedge clk);
        s_valid = '0; sof = 1'b0;
    endtask

    function automatic logic [31:0] lim_word(input int s, input int w);
        int lo, hi;
        lo = 128 + s - w / 2;
        hi = 128 + s + w / 2;
        if (lo < 0) lo = 0;
        if (hi > 255) hi = 255;
        return (32'(hi) << 16) | 32'(lo);
    endfunction

    task automatic t_reset();
        logic [31:0] d;
        for (int c = 0; c < NCH; c++) begin
            rd(c, 0, d); chk("R1 cfg", d, 0);
            rd(c, 1, d); chk("R1 above", d, 0);
            rd(c, 2, d); chk("R1 below", d, 0);
            rd(c, 3, d); chk("R1 limits", d, lim_word(0, 0));
        end
        rd(3, 1, d); chk("R9 unmapped", d, 0);
    endtask

    task automatic t_deferred();
        logic [31:0] d;
        wr(0, 0, (32'd20 << 16) | 32'd5);
        rd(0, 0, d); chk("R8 cfg readback", d, (32'd20 << 16) | 32'd5);
        rd(0, 3, d); chk("R8 limits held", d, lim_word(0, 0));
        push(3'b001, 130, 0, 0, 1'b0);
        rd(0, 1, d); chk("R8 old window used", d, 1);
        push(3'b000, 0, 0, 0, 1'b1);
        rd(0, 3, d); chk("R2 new limits", d, lim_word(5, 20));
        rd(0, 1, d); chk("R7 above cleared", d, 0);
    endtask

    task automatic t_boundary();
        logic [31:0] d;
        push(3'b001, 122, 0, 0, 1'b0);
        push(3'b001, 123, 0, 0, 1'b0);
        push(3'b001, 143, 0, 0, 1'b0);
        push(3'b001, 144, 0, 0, 1'b0);
        push(3'b001, 133, 0, 0, 1'b0);
        rd(0, 1, d); chk("R3 above", d, 1);
        rd(0, 2, d); chk("R3 below", d, 1);
        push(3'b000, 200, 0, 0, 1'b0);
        rd(0, 1, d); chk("R5 invalid ignored", d, 1);
    endtask

    task automatic t_clamp();
        logic [31:0] d;
        wr(1, 0, (32'd255 << 16) | 32'h20);
        wr(2, 0, (32'd255 << 16) | 32'h1F);
        push(3'b000, 0, 0, 0, 1'b1);
        rd(1, 3, d); chk("R2 clamp low", d, lim_word(-32, 255));
        rd(2, 3, d); chk("R2 clamp high", d, lim_word(31, 255));
        rd(0, 3, d); chk("R2 ch0 kept", d, lim_word(5, 20));
    endtask

    task automatic t_independent();
        logic [31:0] d;
        push(3'b111, 150, 0, 31, 1'b0);
        push(3'b110, 0, 224, 255, 1'b0);
        rd(0, 1, d); chk("R4 ch0 above", d, 1);
        rd(0, 2, d); chk("R4 ch0 below", d, 0);
        rd(1, 1, d); chk("R4 ch1 above", d, 1);
        rd(1, 2, d); chk("R4 ch1 below", d, 0);
        rd(2, 1, d); chk("R4 ch2 above", d, 0);
        rd(2, 2, d); chk("R4 ch2 below", d, 1);
    endtask

    task automatic t_sof_sample();
        logic [31:0] d;
        wr(0, 0, 32'd0);
        push(3'b001, 130, 0, 0, 1'b1);
        rd(0, 3, d); chk("R7 limits loaded", d, lim_word(0, 0));
        rd(0, 1, d); chk("R7 sample on pulse", d, 1);
        rd(2, 2, d); chk("R7 other channel cleared", d, 0);
    endtask

    task automatic t_saturate();
        logic [31:0] d;
        for (int i = 0; i < 300; i++) push(3'b001, 255, 0, 0, 1'b0);
        rd(0, 1, d); chk("R6 saturated", d, 255);
        push(3'b001, 3, 0, 0, 1'b0);
        rd(0, 1, d); chk("R6 still saturated", d, 255);
        rd(0, 2, d); chk("R6 other counter", d, 1);
        push(3'b000, 0, 0, 0, 1'b1);
        rd(0, 1, d); chk("R7 clear after sat", d, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_deferred();
        t_boundary();
        t_clamp();
        t_independent();
        t_sof_sample();
        t_saturate();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule